// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block picks the larger or the smaller of two IEEE 754 binary operands. One opcode bit chooses the operation. The operand width is a parameter and may be 16, 32 or 64 bits. The exponent and mantissa widths follow from that parameter.

The unit never raises an exception on NaN inputs. If only one operand is a NaN, the other operand is returned. If both operands are NaN, the result is a fixed quiet NaN.

The ordering is found by comparing the exponent-and-mantissa bits as an unsigned integer and then applying the sign bits, so no floating-point subtractor is needed. An optional output register with a valid/ready handshake adds one cycle of latency and holds the result while the consumer stalls.

Top module: `fp_minmax`

## Requirements
- R1: The result is always bit-identical to operand A, to operand B, or to the canonical quiet NaN. The canonical quiet NaN has sign 0, an exponent of all ones, the top mantissa bit set and all other bits 0 (0x7FC00000 at width 32).
- R2: When both operands are NaN, quiet or signalling, the result is the canonical quiet NaN.
- R3: When exactly one operand is NaN, the result is the other operand unchanged.
- R4: An operand is NaN when its exponent field is all ones and its mantissa field is non-zero. Infinities (all-ones exponent, zero mantissa) take part in normal ordering.
- R5: opc_i = 0 selects the maximum and opc_i = 1 selects the minimum.
- R6: When the sign bits differ, the negative operand is the smaller. So max(+0, -0) = +0 and min(+0, -0) = -0.
- R7: When the sign bits match, the low WIDTH-1 bits are compared as unsigned integers, and the order is reversed for negative operands. This also holds for subnormals.
- R8: Bit-identical operands return that same value for both opcodes.
- R9: With PIPE = 1, an operand pair is accepted on a clock edge where in_valid_i and in_ready_o are both high. Its result appears on res_o with out_valid_o high after that edge.
- R10: With PIPE = 1, while out_valid_o is high and out_ready_i is low, res_o and out_valid_o hold steady and in_ready_o is low. After reset, out_valid_o is low and in_ready_o is high.

Top module ports follow in list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operand pair valid |
| in_ready_o | output | 1 | Unit can accept an operand pair |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| opc_i | input | 1 | 0 = maximum, 1 = minimum |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| res_o | output | WIDTH | Selected result |

## Verification
The pattern sets are chosen so that each one separates a different part of the selection.
- Operands of opposite sign, including the signed-zero pair, separate the sign rule from the magnitude compare.
- Same-sign pairs of both signs, including subnormals and infinities, show whether the magnitude order is reversed for negative values.
- Quiet and signalling NaNs paired with numbers and with each other separate pass-through of the non-NaN operand from generation of the canonical NaN. Infinities confirm that an all-ones exponent alone is not taken as NaN.
- Random operand pairs are checked against an ordering-key model, and a stall sequence checks that the held result and back-pressure behave correctly.

// File: rtl/fp_minmax_pkg.sv
package fp_minmax_pkg;
  typedef enum logic {OP_MAX = 1'b0, OP_MIN = 1'b1} op_e;

  function automatic int exp_bits(input int w);
    case (w)
      16:      return 5;
      64:      return 11;
      default: return 8;
    endcase
  endfunction

  function automatic int man_bits(input int w);
    return w - 1 - exp_bits(w);
  endfunction
endpackage

// File: rtl/fp_nan_detect.sv
module fp_nan_detect
  import fp_minmax_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_i,
  output logic             nan_o
);
  localparam int EXP_W = exp_bits(WIDTH);
  localparam int MAN_W = man_bits(WIDTH);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = op_i[WIDTH-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];
  assign nan_o = (&exp_f) & (|man_f);
endmodule

// File: rtl/fp_mag_order.sv
module fp_mag_order #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             b_larger_o
);
  logic sa, sb, mag_lt;

  assign sa     = a_i[WIDTH-1];
  assign sb     = b_i[WIDTH-1];
  assign mag_lt = a_i[WIDTH-2:0] < b_i[WIDTH-2:0];

  // negative side wins smaller; same sign: reverse order when negative
  assign b_larger_o = (sa != sb) ? (sa & ~sb) : (mag_lt ^ sa);
endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
  import fp_minmax_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_nan_i,
  input  logic             b_nan_i,
  input  logic             b_larger_i,
  input  op_e              op_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int EXP_W = exp_bits(WIDTH);
  localparam int MAN_W = man_bits(WIDTH);
  localparam logic [WIDTH-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  always_comb begin
    if (a_nan_i && b_nan_i)      res_o = QNAN;
    else if (a_nan_i)            res_o = b_i;
    else if (b_nan_i)            res_o = a_i;
    else if (op_i ^ b_larger_i)  res_o = b_i;
    else                         res_o = a_i;
  end
endmodule

// File: rtl/fp_out_stage.sv
module fp_out_stage #(
  parameter int WIDTH = 32,
  parameter bit PIPE  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] data_o
);
  if (PIPE) begin : g_reg
    logic             valid_q;
    logic [WIDTH-1:0] data_q;
    logic             load;

    assign in_ready_o = ~valid_q | out_ready_i;
    assign load       = in_valid_i & in_ready_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else if (load) begin
        valid_q <= 1'b1;
        data_q  <= data_i;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end

    assign out_valid_o = valid_q;
    assign data_o      = data_q;

    a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(data_o)));
    a_r10_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !out_ready_i) |-> !in_ready_o);
    a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> (out_valid_o && data_o == $past(data_i)));
  end else begin : g_pass
    assign in_ready_o  = out_ready_i;
    assign out_valid_o = in_valid_i;
    assign data_o      = data_i;
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax
  import fp_minmax_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter bit PIPE  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             opc_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int EXP_W = exp_bits(WIDTH);
  localparam int MAN_W = man_bits(WIDTH);
  localparam logic [WIDTH-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [1:0]       nan_v;
  logic [WIDTH-1:0] ops [2];
  logic             b_larger;
  logic [WIDTH-1:0] sel_res;
  op_e              op;

  assign ops[0] = a_i;
  assign ops[1] = b_i;
  assign op     = op_e'(opc_i);

  for (genvar i = 0; i < 2; i++) begin : g_nan
    fp_nan_detect #(.WIDTH(WIDTH)) u_nan (.op_i(ops[i]), .nan_o(nan_v[i]));
  end

  fp_mag_order #(.WIDTH(WIDTH)) u_order (
    .a_i(a_i), .b_i(b_i), .b_larger_o(b_larger)
  );

  fp_minmax_sel #(.WIDTH(WIDTH)) u_sel (
    .a_i(a_i), .b_i(b_i), .a_nan_i(nan_v[0]), .b_nan_i(nan_v[1]),
    .b_larger_i(b_larger), .op_i(op), .res_o(sel_res)
  );

  fp_out_stage #(.WIDTH(WIDTH), .PIPE(PIPE)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .data_i(sel_res), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .data_o(res_o)
  );

  a_r1_operand_or_qnan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (sel_res == a_i || sel_res == b_i || sel_res == QNAN));
  a_r2_both_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && nan_v == 2'b11) |-> sel_res == QNAN);
  a_r3_one_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && nan_v == 2'b01) |-> sel_res == b_i);
  a_r6_sign_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && nan_v == 2'b00 && a_i[WIDTH-1] != b_i[WIDTH-1])
      |-> sel_res[WIDTH-1] == opc_i);
  a_r8_identical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && a_i == b_i && nan_v == 2'b00) |-> sel_res == a_i);
endmodule

// File: tb/fp_minmax_bench.sv
module fp_minmax_bench;
  localparam int W = 32;
  localparam logic [W-1:0] QNAN = 32'h7FC0_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, out_ready = 1'b1, opc = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         in_ready, out_valid;
  logic [W-1:0] res;
  int           n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  fp_minmax #(.WIDTH(W), .PIPE(1'b1)) u_fp_minmax (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .opc_i(opc), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .res_o(res)
  );

  function automatic bit is_nan(input logic [W-1:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // total-order key: larger key = larger value
  function automatic logic [W-1:0] okey(input logic [W-1:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic op);
    if (is_nan(x) && is_nan(y)) return QNAN;
    if (is_nan(x)) return y;
    if (is_nan(y)) return x;
    if (op == 1'b0) return (okey(y) > okey(x)) ? y : x;
    return (okey(y) < okey(x)) ? y : x;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic op, input logic [W-1:0] exp);
    @(negedge clk);
    a = x; b = y; opc = op; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'b0, out_valid}, 32'd1);
    check(req, res, exp);
  endtask

  task automatic t_reset;
    check("R10 reset valid", {31'b0, out_valid}, 32'd0);
    check("R10 reset ready", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_nan;
    run_op("R2 qnan+qnan", 32'h7FC0_1234, 32'hFFC0_0001, 1'b0, QNAN);
    run_op("R2 snan+snan min", 32'h7F80_0001, 32'hFF80_0010, 1'b1, QNAN);
    run_op("R3 nan,num", 32'h7FC0_0000, 32'hC040_0000, 1'b0, 32'hC040_0000);
    run_op("R3 num,snan", 32'h3F80_0000, 32'hFF80_0001, 1'b1, 32'h3F80_0000);
    run_op("R1 qnan canonical", 32'hFFFF_FFFF, 32'h7F80_0001, 1'b1, QNAN);
  endtask

  task automatic t_inf;
    run_op("R4 +inf max", 32'h7F80_0000, 32'h4000_0000, 1'b0, 32'h7F80_0000);
    run_op("R4 -inf min", 32'h3F80_0000, 32'hFF80_0000, 1'b1, 32'hFF80_0000);
    run_op("R4 inf vs inf", 32'hFF80_0000, 32'h7F80_0000, 1'b0, 32'h7F80_0000);
  endtask

  task automatic t_sign;
    run_op("R6 max +0,-0", 32'h8000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000);
    run_op("R6 min +0,-0", 32'h0000_0000, 32'h8000_0000, 1'b1, 32'h8000_0000);
    run_op("R5 R6 max mixed", 32'hC2C8_0000, 32'h3DCC_CCCD, 1'b0, 32'h3DCC_CCCD);
    run_op("R5 R6 min mixed", 32'h3DCC_CCCD, 32'hC2C8_0000, 1'b1, 32'hC2C8_0000);
  endtask

  task automatic t_mag;
    run_op("R7 pos max", 32'h4120_0000, 32'h4140_0000, 1'b0, 32'h4140_0000);
    run_op("R7 pos min", 32'h4120_0000, 32'h4140_0000, 1'b1, 32'h4120_0000);
    run_op("R7 neg max", 32'hC120_0000, 32'hC140_0000, 1'b0, 32'hC120_0000);
    run_op("R7 neg min", 32'hC120_0000, 32'hC140_0000, 1'b1, 32'hC140_0000);
    run_op("R7 subnormal max", 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0000_0002);
    run_op("R7 neg subnormal min", 32'h8000_0001, 32'h8000_0003, 1'b1, 32'h8000_0003);
  endtask

  task automatic t_equal;
    run_op("R8 equal max", 32'hBF80_0000, 32'hBF80_0000, 1'b0, 32'hBF80_0000);
    run_op("R8 equal min", 32'h4049_0FDB, 32'h4049_0FDB, 1'b1, 32'h4049_0FDB);
  endtask

  task automatic t_stall;
    @(negedge clk);
    a = 32'h4000_0000; b = 32'h4040_0000; opc = 1'b0; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R9 stall first valid", {31'b0, out_valid}, 32'd1);
    check("R9 stall first data", res, 32'h4040_0000);
    a = 32'h3F00_0000; b = 32'hBF00_0000; opc = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held data", res, 32'h4040_0000);
      check("R10 ready low", {31'b0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next after stall", res, 32'hBF00_0000);
    @(negedge clk);
    check("R10 drained", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x, y;
      logic op;
      x = $urandom;
      y = (i % 5 == 0) ? {~x[31], x[30:0]} : $urandom;
      if (i % 7 == 0) y[30:23] = 8'hFF;
      op = i[0];
      run_op("R1 R5 random", x, y, op, model(x, y, op));
      n_run++;
      if (!(res == x || res == y || res == QNAN)) begin
        n_fail++;
        $display("FAIL R1: got %h expected one of %h %h %h", res, x, y, QNAN);
      end
    end
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nan();
    t_inf();
    t_sign();
    t_mag();
    t_equal();
    t_stall();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule